// File: doc/BRIEF.md
# Fan Speed Command Slave (Two-Wire Send/Receive Byte)

This block is a two-wire serial bus slave that answers one fixed 7-bit address and knows only two transactions. In a write (send byte), the host sends one command byte. Its low six bits set the fan drive code and bit 6 requests a boost start. In a read (receive byte), the slave returns one status byte that reports the live over-current and over-temperature flags. The clock and data lines are sampled from the system clock through synchronizers. SDA is pulled low only through an open-drain enable.

The downstream logic receives the latched 6-bit code, the boost bit and a one-cycle update strobe. A command only takes effect at the falling clock edge that closes its acknowledge. A transaction cut short by a stop leaves the drive code as it was.

The state machine has these states. IDLE waits for a start. ADDR shifts in address and direction. AACK acknowledges the address. CMD shifts in the command. CACK acknowledges the command and commits it on its closing falling edge. TX shifts out the status byte. SKIP ignores the bus.

The transitions are as follows. A start goes from any state to ADDR. A stop goes from any state to IDLE. ADDR goes to AACK on a match and to SKIP otherwise, after the 8th falling edge. AACK goes to CMD for a write or to TX for a read, on its falling edge. CMD goes to CACK after 8 bits. CACK goes to SKIP with a commit. TX goes to SKIP after 8 bits, and the host's ninth-clock not-acknowledge arrives while the slave is in SKIP.

Top module: `fanctl_smb_slave`

## Requirements
- R1: After reset, the drive code is 0, the boost bit is 0, the update strobe is low and SDA is released.
- R2: A start followed by address 1110100 (first bit = address bit 6) and direction bit 0 is acknowledged: SDA reads low during the high phase of the 9th clock. The command byte is acknowledged the same way.
- R3: The command's bits 5..0 become the drive code and bit 6 becomes the boost bit only after the falling SCL edge that ends the command acknowledge. During that acknowledge's high phase, the old value is still presented.
- R4: Command bit 7 has no effect on the drive code or the boost bit.
- R5: A stop before the command acknowledge completes leaves the drive code and the boost bit unchanged, and produces no update strobe.
- R6: For any other address, SDA stays released in the 9th clock, and a command byte that follows does not change the drive code.
- R7: With direction bit 1 at the matching address, the slave acknowledges and then returns a byte, MSB first, with bit 7 = over-current input, bit 6 = over-temperature input, and bits 5..0 = 0.
- R8: Each commit raises the update strobe for exactly one clock, including when the new value equals the old one.
- R9: A read transaction does not change the drive code or the boost bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on / undervoltage) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| ovc_i | input | 1 | Live over-current flag |
| ovt_i | input | 1 | Live over-temperature flag |
| code_o | output | 6 | Latched fan drive code |
| boost_o | output | 1 | Latched boost-start request |
| upd_o | output | 1 | One-cycle strobe on every commit |

## Verification
Writes use all-zero, all-one, mixed and repeated command values. The all-one value with bit 7 set separates the don't-care bit from the boost bit. The repeated value shows that the strobe does not depend on a change. Cut-short writes and writes to a wrong address are compared with complete ones to show that only a full acknowledge commits. Reads with each combination of fault flags show the position of each flag, and a read placed between writes shows that reads leave the drive code alone.

// File: rtl/fanctl_smb_pkg.sv
package fanctl_smb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_CMD,
        ST_CACK,
        ST_TX,
        ST_SKIP
    } smb_st_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= line_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm
    import fanctl_smb_pkg::*;
#(
    parameter logic [6:0] ADDR   = 7'b1110100,
    parameter int         CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic              ovc_i,
    input  logic              ovt_i,
    output logic              sda_oe,
    output logic [CODE_W-1:0] code_o,
    output logic              boost_o,
    output logic              upd_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int BST_POS = CODE_W;

    smb_st_e             state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [BYTE_W-1:0]   rx_q;
    logic [BYTE_W-1:0]   tx_q;
    logic [CODE_W-1:0]   code_q;
    logic                boost_q;
    logic                upd_q;
    logic                start_ev, stop_ev, byte_done;

    assign start_ev  = sda_fall & scl_lvl;
    assign stop_ev   = sda_rise & scl_lvl;
    assign byte_done = (cnt_q == CNT_W'(BYTE_W));

    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: if (scl_fall && byte_done)
                             state_d = (rx_q[BYTE_W-1:1] == ADDR) ? ST_AACK : ST_SKIP;
                ST_AACK: if (scl_fall) state_d = rx_q[0] ? ST_TX : ST_CMD;
                ST_CMD:  if (scl_fall && byte_done) state_d = ST_CACK;
                ST_CACK: if (scl_fall) state_d = ST_SKIP;
                ST_TX:   if (scl_fall && cnt_q == CNT_W'(BYTE_W - 1)) state_d = ST_SKIP;
                ST_SKIP: state_d = ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            code_q  <= '0;
            boost_q <= 1'b0;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (start_ev || stop_ev) begin
                cnt_q <= '0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_CMD: if (scl_rise && !byte_done) begin
                        rx_q  <= {rx_q[BYTE_W-2:0], sda_lvl};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    ST_AACK: if (scl_fall) begin
                        cnt_q <= '0;
                        tx_q  <= {ovc_i, ovt_i, {(BYTE_W-2){1'b0}}};
                    end
                    ST_CACK: if (scl_fall) begin
                        code_q  <= rx_q[CODE_W-1:0];
                        boost_q <= rx_q[BST_POS];
                        upd_q   <= 1'b1;
                    end
                    ST_TX: if (scl_fall) begin
                        tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        unique case (state_q)
            ST_AACK, ST_CACK: sda_oe = 1'b1;
            ST_TX:            sda_oe = ~tx_q[BYTE_W-1];
            default:          sda_oe = 1'b0;
        endcase
    end

    assign code_o  = code_q;
    assign boost_o = boost_q;
    assign upd_o   = upd_q;

    // R8
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |=> !upd_q);

    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q) || boost_q != $past(boost_q)) |-> upd_q);

    // R5
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> ($stable(code_q) && $stable(boost_q) && !upd_q));

    // R2
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);
endmodule

// File: rtl/fanctl_smb_slave.sv
module fanctl_smb_slave #(
    parameter logic [6:0] ADDR        = 7'b1110100,
    parameter int         CODE_W      = 6,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              ovc_i,
    input  logic              ovt_i,
    output logic [CODE_W-1:0] code_o,
    output logic              boost_o,
    output logic              upd_o
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;

    smb_line_sync #(.STAGES(SYNC_STAGES)) scl_sync_i (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    smb_line_sync #(.STAGES(SYNC_STAGES)) sda_sync_i (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    smb_byte_fsm #(.ADDR(ADDR), .CODE_W(CODE_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .ovc_i(ovc_i), .ovt_i(ovt_i),
        .sda_oe(sda_oe), .code_o(code_o), .boost_o(boost_o), .upd_o(upd_o)
    );
endmodule

// File: tb/fanctl_smb_slave_tb.sv
module fanctl_smb_slave_tb_top;
    localparam int Q = 10;
    localparam logic [6:0] MY_ADDR = 7'b1110100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       host_sda = 1'b1;
    logic       ovc = 1'b0, ovt = 1'b0;
    logic       sda_oe;
    logic [5:0] code_o;
    logic       boost_o, upd_o;
    wire        sda_line = host_sda & ~sda_oe;

    int checks = 0, fails = 0;
    int upd_cnt = 0, upd_wide = 0;
    logic upd_prev = 1'b0;
    logic [5:0] exp_code = '0;
    logic       exp_boost = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;

    fanctl_smb_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .ovc_i(ovc), .ovt_i(ovt),
        .code_o(code_o), .boost_o(boost_o), .upd_o(upd_o)
    );

    always @(negedge clk) begin
        if (upd_o) upd_cnt++;
        if (upd_o && upd_prev) upd_wide++;
        upd_prev = upd_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; scl = 1'b1; w(Q);
        host_sda = 1'b0; w(Q);
        scl = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; w(Q);
        scl = 1'b1; w(Q);
        host_sda = 1'b1; w(2*Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        host_sda = b; w(Q);
        scl = 1'b1; w(Q);
        s = sda_line; w(Q);
        scl = 1'b0; w(Q);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) clk_bit(v[i], s);
    endtask

    // sends the 8 data bits and the ack clock; returns SDA during ack high
    task automatic send_byte(input logic [7:0] v, output logic ack_lvl);
        send_bits(v, 8);
        clk_bit(1'b1, ack_lvl);
    endtask

    task automatic do_write(input logic [7:0] cmd, input string req);
        logic a;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a);
        check(a == 1'b0, "R2 address ack", a, 0);
        send_bits(cmd, 8);
        host_sda = 1'b1; w(Q);
        scl = 1'b1; w(Q);
        a = sda_line;
        check(a == 1'b0, "R2 command ack", a, 0);
        check(code_o == exp_code && boost_o == exp_boost, "R3 old value held during ack",
              {boost_o, code_o}, {exp_boost, exp_code});
        w(Q);
        scl = 1'b0; w(Q);
        exp_code = cmd[5:0];
        exp_boost = cmd[6];
        check(code_o == exp_code && boost_o == exp_boost, req,
              {boost_o, code_o}, {exp_boost, exp_code});
        bus_stop();
    endtask

    task automatic t_reset();
        check(code_o == 6'd0, "R1 code", code_o, 0);
        check(boost_o == 1'b0, "R1 boost", boost_o, 0);
        check(upd_o == 1'b0 && sda_oe == 1'b0, "R1 strobe/sda", {upd_o, sda_oe}, 0);
    endtask

    task automatic t_writes();
        int c0 = upd_cnt;
        do_write(8'h2A, "R3 commit mixed");
        do_write(8'h45, "R3 commit boost");
        do_write(8'hFF, "R4 bit7 ignored all-ones");
        do_write(8'h80, "R4 bit7 ignored zero code");
        check(upd_cnt == c0 + 4, "R8 strobe per write", upd_cnt, c0 + 4);
    endtask

    task automatic t_same_value();
        int c0;
        do_write(8'h5B, "R8 first write");
        c0 = upd_cnt;
        do_write(8'h5B, "R8 repeat write");
        check(upd_cnt == c0 + 1, "R8 strobe on unchanged value", upd_cnt, c0 + 1);
    endtask

    task automatic t_early_stop();
        logic a;
        int c0 = upd_cnt;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a);
        send_bits(8'h13, 5);
        bus_stop();
        check(code_o == exp_code && boost_o == exp_boost, "R5 early stop keeps value",
              {boost_o, code_o}, {exp_boost, exp_code});
        check(upd_cnt == c0, "R5 no strobe", upd_cnt, c0);
    endtask

    task automatic t_wrong_addr();
        logic a;
        int c0 = upd_cnt;
        bus_start();
        send_byte({7'b1110101, 1'b0}, a);
        check(a == 1'b1, "R6 no ack", a, 1);
        send_byte(8'h3C, a);
        check(a == 1'b1, "R6 no command ack", a, 1);
        bus_stop();
        check(code_o == exp_code && upd_cnt == c0, "R6 code unchanged",
              code_o, exp_code);
    endtask

    task automatic t_read(input logic oc, input logic ot);
        logic a, s;
        logic [7:0] got;
        ovc = oc; ovt = ot;
        bus_start();
        send_byte({MY_ADDR, 1'b1}, a);
        check(a == 1'b0, "R7 read address ack", a, 0);
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            got[i] = s;
        end
        clk_bit(1'b1, s);
        bus_stop();
        check(got == {oc, ot, 6'b0}, "R7 status byte", got, {oc, ot, 6'b0});
        check(code_o == exp_code && boost_o == exp_boost, "R9 read leaves code",
              {boost_o, code_o}, {exp_boost, exp_code});
        ovc = 1'b0; ovt = 1'b0;
    endtask

    initial begin
        w(5);
        rst_n = 1'b1;
        w(5);
        t_reset();
        t_writes();
        t_read(1'b1, 1'b1);
        t_read(1'b0, 1'b1);
        t_read(1'b1, 1'b0);
        t_same_value();
        t_early_stop();
        t_wrong_addr();
        do_write(8'h07, "R6 slave recovers after ignore");
        t_read(1'b0, 1'b0);
        check(upd_wide == 0, "R8 strobe width", upd_wide, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule